// File: doc/BRIEF.md
# DRAM Refresh and Scrub Sequencer

This block keeps two DRAM banks refreshed and scrubs one location on every refresh. A down-counting interval timer, clocked by the system clock, raises a refresh request towards the memory arbiter. After the arbiter grants, the block runs a burst of four row-strobe cycles. Both banks get row strobe in every cycle, and the refresh row counter moves up by one after each cycle. In the first cycle of the burst the block also drives column strobe to one bank. On that bank it holds output enable for a few clocks, leaving time for an external correction step, and then holds write enable. That read followed by a write is the scrub of the addressed location.

The bank that receives the scrub changes whenever the row counter wraps from all ones back to zero. If only one bank is populated, every scrub goes to that bank. The refresh interval is about 60 µs by default and about 30 µs when the fast-refresh input is high. The request/grant pair is a level handshake. The request stays high from the moment it is raised until the last cycle of the burst has finished. Grant is acted on only while a request is waiting, and the arbiter cannot take the memory back in the middle of a burst. No data passes through the block. The presence inputs must not change while the request is high.

Top module: `refscrub_seq`

## Requirements
- R1: After reset, ref_req is low, all strobe outputs (ras_n, cas_n, oe_n, we_n) are high, and row_addr is zero.
- R2: ref_req rises exactly RELOAD clock cycles after the block becomes idle, counted either from reset release or from the end of the previous burst. RELOAD is CLK_MHZ*60 when fast_ref was low at that point and CLK_MHZ*30 when it was high.
- R3: Once ref_req has risen, it stays high until the burst completes, and no row strobe is driven before ref_gnt is seen. A ref_gnt that arrives while no request is pending is ignored: ref_req stays low and no strobe moves.
- R4: The cycle after the grant is sampled, the burst starts. It consists of exactly four row cycles, each made of T_RAS clocks with both ras_n bits low followed by T_RP clocks with both high. ref_req drops after the fourth precharge.
- R5: Only in the first row cycle of a burst, cas_n of the scrub bank is low for all T_RAS active clocks. On that bank, oe_n is low for the first T_OE clocks and we_n is low for the remaining T_RAS-T_OE clocks, and the two are never low together. The other bank's cas_n, oe_n and we_n stay high throughout.
- R6: row_addr holds steady during a row cycle and increments by one at the end of each cycle. After all ones it wraps to zero.
- R7: When both banks are present, the scrub goes to bank A (bit 0 of each two-bit strobe bus) until the first row wrap. The target then swaps between A and B (bit 1) on every wrap.
- R8: If only one bank is present, every scrub targets that bank. If neither bank is present, no cas_n, oe_n or we_n is ever driven low, but refresh still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_ref | input | 1 | Selects the halved refresh interval |
| bank_a_present | input | 1 | Bank A is populated |
| bank_b_present | input | 1 | Bank B is populated |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Refresh request, held until the burst ends |
| ras_n | output | 2 | Row strobe per bank, active low (bit 0 = A) |
| cas_n | output | 2 | Column strobe per bank, active low |
| oe_n | output | 2 | Output enable per bank, active low |
| we_n | output | 2 | Write enable per bank, active low |
| row_addr | output | ROW_W | Row currently being refreshed |

## Verification
The bench runs a long chain of bursts with a narrow row counter, so that the counter wraps several times. Across these bursts it changes the grant delay and the fast-refresh setting at random, and it also drives stray grant pulses while the block is idle. Comparing the measured idle gap against the two reload values shows which fast-refresh setting the timer latched at the end of each burst. The stray grants would reveal any case where a grant leaks past the request. The presence inputs are run through all four combinations, with both banks present across several wraps. This separates the alternation rule from the single-bank rule and from the case where no scrub is issued.

// File: rtl/refscrub_pkg.sv
package refscrub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACT  = 2'd2,
    ST_PRE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/refscrub_timer.sv
module refscrub_timer #(
  parameter int CLK_MHZ = 50,
  parameter int SLOW_US = 60,
  parameter int FAST_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  input  logic fast_ref,
  output logic expire
);
  localparam int SLOW_CNT = CLK_MHZ * SLOW_US;
  localparam int FAST_CNT = CLK_MHZ * FAST_US;
  localparam int CNT_W    = $clog2(SLOW_CNT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;

  assign reload_val = fast_ref ? CNT_W'(FAST_CNT - 1) : CNT_W'(SLOW_CNT - 1);
  assign expire     = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= CNT_W'(SLOW_CNT - 1);
    else if (load)                cnt_q <= reload_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/refscrub_burst.sv
module refscrub_burst
  import refscrub_pkg::*;
#(
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int CYCLES = 4,
  localparam int TICK_W = $clog2(((T_RAS > T_RP) ? T_RAS : T_RP) + 1),
  localparam int CYC_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              gnt,
  output seq_state_t        state,
  output logic [CYC_W-1:0]  cyc_idx,
  output logic [TICK_W-1:0] tick,
  output logic              cyc_end,
  output logic              done
);
  seq_state_t        state_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [TICK_W-1:0] tick_q;
  logic              act_last;
  logic              pre_last;

  assign act_last = (state_q == ST_ACT) && (tick_q == TICK_W'(T_RAS - 1));
  assign pre_last = (state_q == ST_PRE) && (tick_q == TICK_W'(T_RP - 1));
  assign cyc_end  = pre_last;
  assign done     = pre_last && (cyc_q == CYC_W'(CYCLES - 1));
  assign state    = state_q;
  assign cyc_idx  = cyc_q;
  assign tick     = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      tick_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (expire) state_q <= ST_WAIT;
        ST_WAIT: if (gnt) begin
          state_q <= ST_ACT;
          cyc_q   <= '0;
          tick_q  <= '0;
        end
        ST_ACT: begin
          if (act_last) begin
            state_q <= ST_PRE;
            tick_q  <= '0;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        ST_PRE: begin
          if (pre_last) begin
            tick_q <= '0;
            if (done) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_ACT;
              cyc_q   <= cyc_q + 1'b1;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refscrub_rowbank.sv
module refscrub_rowbank #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row,
  output logic             bank_sel
);
  logic [ROW_W-1:0] row_q;
  logic             sel_q;

  assign row      = row_q;
  assign bank_sel = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      sel_q <= 1'b0;
    end else if (advance) begin
      row_q <= row_q + 1'b1;
      if (&row_q) sel_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/refscrub_seq.sv
module refscrub_seq
  import refscrub_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int ROW_W   = 11,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_OE    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_ref,
  input  logic             bank_a_present,
  input  logic             bank_b_present,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic [1:0]       ras_n,
  output logic [1:0]       cas_n,
  output logic [1:0]       oe_n,
  output logic [1:0]       we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int CYCLES = 4;
  localparam int TICK_W = $clog2(((T_RAS > T_RP) ? T_RAS : T_RP) + 1);
  localparam int CYC_W  = $clog2(CYCLES);

  seq_state_t        state;
  logic [CYC_W-1:0]  cyc_idx;
  logic [TICK_W-1:0] tick;
  logic              cyc_end;
  logic              done;
  logic              expire;
  logic              bank_sel;
  logic              scrub_on;
  logic              oe_phase;
  logic [1:0]        target;

  refscrub_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE), .load(done),
    .fast_ref(fast_ref), .expire(expire)
  );

  refscrub_burst #(.T_RAS(T_RAS), .T_RP(T_RP), .CYCLES(CYCLES)) u_burst (
    .clk(clk), .rst_n(rst_n), .expire(expire), .gnt(ref_gnt),
    .state(state), .cyc_idx(cyc_idx), .tick(tick),
    .cyc_end(cyc_end), .done(done)
  );

  refscrub_rowbank #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .advance(cyc_end),
    .row(row_addr), .bank_sel(bank_sel)
  );

  always_comb begin
    unique case ({bank_b_present, bank_a_present})
      2'b11:   target = bank_sel ? 2'b10 : 2'b01;
      2'b01:   target = 2'b01;
      2'b10:   target = 2'b10;
      default: target = 2'b00;
    endcase
  end

  assign ref_req  = (state != ST_IDLE);
  assign scrub_on = (state == ST_ACT) && (cyc_idx == '0);
  assign oe_phase = (tick < TICK_W'(T_OE));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign ras_n[b] = ~(state == ST_ACT);
    assign cas_n[b] = ~(target[b] & scrub_on);
    assign oe_n[b]  = ~(target[b] & scrub_on & oe_phase);
    assign we_n[b]  = ~(target[b] & scrub_on & ~oe_phase);
  end
endmodule

// File: rtl/refscrub_seq_chk.sv
module refscrub_seq_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bank_a_present,
  input logic             bank_b_present,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic [1:0]       ras_n,
  input logic [1:0]       cas_n,
  input logic [1:0]       oe_n,
  input logic [1:0]       we_n,
  input logic [ROW_W-1:0] row_addr
);
  assert_ras_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> ref_req);

  assert_ras_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n[0] == ras_n[1]);

  assert_cas_in_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11) |-> (ras_n == 2'b00));

  assert_one_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cas_n) <= 1);

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~oe_n) & (~we_n)) == 2'b00);

  assert_we_after_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n[0]) |-> $past(!oe_n[0]));

  assert_row_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n[0] && $past(!ras_n[0])) |-> $stable(row_addr));

  assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  assert_missing_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_a_present |-> cas_n[0]);

  assert_missing_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_b_present |-> cas_n[1]);
endmodule

bind refscrub_seq refscrub_seq_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/refscrub_seq_tb.sv
module refscrub_seq_tb;
  localparam int CLK_MHZ = 50;
  localparam int ROW_W   = 4;
  localparam int T_RAS   = 6;
  localparam int T_RP    = 3;
  localparam int T_OE    = 2;
  localparam int NBURST  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_ref = 1'b0;
  logic bank_a_present = 1'b1;
  logic bank_b_present = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req;
  logic [1:0] ras_n, cas_n, oe_n, we_n;
  logic [ROW_W-1:0] row_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  refscrub_seq #(.CLK_MHZ(CLK_MHZ), .ROW_W(ROW_W), .T_RAS(T_RAS),
                 .T_RP(T_RP), .T_OE(T_OE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_ref(fast_ref),
    .bank_a_present(bank_a_present), .bank_b_present(bank_b_present),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
    .oe_n(oe_n), .we_n(we_n), .row_addr(row_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_reload(input bit fast);
    return fast ? CLK_MHZ * 30 : CLK_MHZ * 60;
  endfunction

  function automatic logic [1:0] exp_target(input bit a, input bit b, input bit sel);
    if (a && b) return sel ? 2'b10 : 2'b01;
    if (a) return 2'b01;
    if (b) return 2'b10;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 200000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int gap;
    int dly;
    bit cur_fast;
    bit nxt_fast;
    bit exp_sel;
    logic [ROW_W-1:0] exp_row;
    logic [1:0] tgt;
    logic [1:0] e_cas, e_oe, e_we;
    void'($urandom(32'd1234));
    cur_fast = 1'b0;
    exp_sel  = 1'b0;
    exp_row  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(ref_req == 1'b0, "R1 req", ref_req, 0);
    chk(ras_n == 2'b11 && cas_n == 2'b11, "R1 ras/cas", {ras_n, cas_n}, 4'hf);
    chk(oe_n == 2'b11 && we_n == 2'b11, "R1 oe/we", {oe_n, we_n}, 4'hf);
    chk(row_addr == '0, "R1 row", row_addr, 0);
    rst_n = 1'b1;

    for (int n = 0; n < NBURST; n++) begin
      if (n >= 8 && n < 10)       {bank_b_present, bank_a_present} = 2'b01;
      else if (n >= 10 && n < 12) {bank_b_present, bank_a_present} = 2'b10;
      else if (n == 12)           {bank_b_present, bank_a_present} = 2'b00;
      else if (n > 12)            {bank_b_present, bank_a_present} = 2'($urandom);
      else                        {bank_b_present, bank_a_present} = 2'b11;
      // idle gap; stray grants must be ignored (R3)
      gap = 0;
      while (!ref_req && gap < 4000) begin
        chk(ras_n == 2'b11 && cas_n == 2'b11, "R3 idle strobes", {ras_n, cas_n}, 4'hf);
        gap++;
        ref_gnt = (gap < 10) ? 1'($urandom) : 1'b0;
        @(negedge clk);
      end
      ref_gnt = 1'b0;
      // R2: interval, R9 of fast_ref latched at reload folded into R2
      chk(gap == exp_reload(cur_fast), "R2 interval", gap, exp_reload(cur_fast));
      dly = $urandom % 4;
      for (int d = 0; d < dly; d++) begin
        chk(ref_req && ras_n == 2'b11, "R3 wait for grant", {ref_req, ras_n}, 3'b111);
        @(negedge clk);
      end
      nxt_fast = 1'($urandom);
      fast_ref = nxt_fast;
      ref_gnt = 1'b1;
      tgt = exp_target(bank_a_present, bank_b_present, exp_sel);
      for (int k = 0; k < 4; k++) begin
        for (int t = 0; t < T_RAS + T_RP; t++) begin
          @(negedge clk);
          ref_gnt = 1'b0;
          chk(ref_req == 1'b1, "R3 req held", ref_req, 1);
          chk(ras_n == ((t < T_RAS) ? 2'b00 : 2'b11), "R4 ras shape", ras_n,
              (t < T_RAS) ? 0 : 3);
          chk(row_addr == exp_row, "R6 row", row_addr, exp_row);
          e_cas = (k == 0 && t < T_RAS) ? ~tgt : 2'b11;
          e_oe  = (k == 0 && t < T_OE) ? ~tgt : 2'b11;
          e_we  = (k == 0 && t >= T_OE && t < T_RAS) ? ~tgt : 2'b11;
          chk(cas_n == e_cas, (n < 8) ? "R7 scrub bank" : "R8 scrub bank", cas_n, e_cas);
          chk(oe_n == e_oe && we_n == e_we, "R5 oe/we order", {oe_n, we_n}, {e_oe, e_we});
        end
        if (&exp_row) exp_sel = ~exp_sel;
        exp_row = exp_row + 1'b1;
      end
      cur_fast = nxt_fast;
      @(negedge clk);
      chk(ref_req == 1'b0 && ras_n == 2'b11, "R4 burst end", {ref_req, ras_n}, 0 + 3);
      chk(row_addr == exp_row, "R6 row after burst", row_addr, exp_row);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule